// File: doc/BRIEF.md
# STOP Standby Mode Controller

This block sequences a small microcontroller core into and out of its deepest standby mode. The CPU issues a one-cycle strobe when it executes its stop instruction. If the core is running from the main system clock, the controller shuts off the main oscillator and gates the CPU clock. It parks the external bus in a fixed idle pattern, and it turns off the per-peripheral enables that need the main clock. A subsystem oscillator that has been configured keeps running throughout.

An interrupt source releases standby when its request flag is set and its mask flag is clear. On release, the main oscillator is switched back on. The CPU clock stays gated for a stabilization wait, and the length of that wait comes from a 3-bit select input. If such an interrupt is already pending when the strobe arrives, the oscillator is never stopped. The controller goes straight to a halt-style wait of the same length and then resumes normal operation.

Top module: `stop_ctrl`

## Requirements
- R1: `state_o` encodes RUN=0, STOP=1, WAIT=2, HALT_WAIT=3. A strobe in RUN with `sub_clk_sel` low moves the state away from RUN on the next edge. With `sub_clk_sel` high the strobe is ignored: the state stays 0 and all enables are unchanged.
- R2: In STOP, `main_osc_en` is 0 and `x2_pullup_en` is 1. In every other state `main_osc_en` is 1 and `x2_pullup_en` is 0. `sub_osc_en` equals `sub_clk_cfg` in every state.
- R3: The wake condition is any bit i with `irq_req[i]`=1 and `irq_mask[i]`=0. When the wake condition holds in STOP, the state becomes WAIT on the next edge. Requests whose mask bit is 1 leave the block in STOP.
- R4: If the wake condition holds in the same cycle as an honoured strobe, the state becomes HALT_WAIT and `main_osc_en` stays 1.
- R5: The wait lasts N = 2^min(BASE_LOG+STEP_LOG*`ost_sel`, CAP_LOG) cycles, which is 2^(11+2*sel) capped at 2^17 by default. The block spends exactly N cycles in WAIT or HALT_WAIT and then returns to RUN.
- R6: Outside RUN, `ad_lo_oe` is 0, so the low address/data lines are high-impedance. Over the same span, `ad_hi` holds the value that `cpu_ad_hi` had in the last RUN cycle.
- R7: Outside RUN, `astb` is 0 and `wr_n` and `rd_n` are 1.
- R8: `port_q` keeps its value outside RUN. Writes presented with `port_we` outside RUN are ignored. In RUN a write updates `port_q` on the next edge.
- R9: Outside RUN, `cpu_clk_en`, `wdt_en` and `adc_en` are 0. In RUN they are 1.
- R10: Reset gives state RUN, `main_osc_en`=1, bus outputs following the CPU, and `port_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset |
| stop_strobe | input | 1 | One-cycle stop request from the CPU |
| sub_clk_sel | input | 1 | CPU is running from the subsystem clock |
| sub_clk_cfg | input | 1 | Subsystem oscillator is configured |
| irq_req | input | N_IRQ | Interrupt request flags |
| irq_mask | input | N_IRQ | Interrupt mask flags (1 = masked) |
| ost_sel | input | 3 | Stabilization wait select |
| port_d | input | P_W | Port latch write data |
| port_we | input | 1 | Port latch write enable |
| cpu_ad_lo | input | AL_W | CPU low address/data value |
| cpu_ad_oe | input | 1 | CPU low address/data drive enable |
| cpu_ad_hi | input | AH_W | CPU upper address |
| cpu_astb | input | 1 | CPU address strobe |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subsystem oscillator enable |
| x2_pullup_en | output | 1 | Crystal output pin pull-up enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| wdt_en | output | 1 | Watchdog run enable |
| adc_en | output | 1 | A/D converter run enable |
| port_q | output | P_W | Port output latch |
| ad_lo | output | AL_W | Low address/data value |
| ad_lo_oe | output | 1 | Low address/data drive enable |
| ad_hi | output | AH_W | Upper address |
| astb | output | 1 | Address strobe |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| state_o | output | 2 | Current state |

## Verification
The strobe and the wake condition are registered once, so each new state is due one edge after the cycle that presents them. The bench drives inputs on a falling edge and reads `state_o` on the next falling edge. The stabilization wait is measured by counting falling edges from the first one that shows WAIT or HALT_WAIT to the first one that shows RUN. That count must equal N exactly, for every `ost_sel` value. Bus, enable and port outputs are combinational from the state, or registered on the same edge, so they are checked on the same falling edge as the state they belong to.

// File: rtl/stop_ctrl.sv
module stop_ctrl #(
  parameter int N_IRQ    = 8,
  parameter int P_W      = 8,
  parameter int AL_W     = 8,
  parameter int AH_W     = 8,
  parameter int BASE_LOG = 11,
  parameter int STEP_LOG = 2,
  parameter int CAP_LOG  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_strobe,
  input  logic             sub_clk_sel,
  input  logic             sub_clk_cfg,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic [2:0]       ost_sel,
  input  logic [P_W-1:0]   port_d,
  input  logic             port_we,
  input  logic [AL_W-1:0]  cpu_ad_lo,
  input  logic             cpu_ad_oe,
  input  logic [AH_W-1:0]  cpu_ad_hi,
  input  logic             cpu_astb,
  input  logic             cpu_wr_n,
  input  logic             cpu_rd_n,
  output logic             main_osc_en,
  output logic             sub_osc_en,
  output logic             x2_pullup_en,
  output logic             cpu_clk_en,
  output logic             wdt_en,
  output logic             adc_en,
  output logic [P_W-1:0]   port_q,
  output logic [AL_W-1:0]  ad_lo,
  output logic             ad_lo_oe,
  output logic [AH_W-1:0]  ad_hi,
  output logic             astb,
  output logic             wr_n,
  output logic             rd_n,
  output logic [1:0]       state_o
);
  localparam int CW = CAP_LOG + 1;
  localparam logic [1:0] S_RUN = 2'd0, S_STOP = 2'd1, S_WAIT = 2'd2, S_HWAIT = 2'd3;

  logic [1:0]      st;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   last;
  logic [AH_W-1:0] ahi_hold;
  logic            wake, run, waiting;
  int              wlog;

  assign wake    = |(irq_req & ~irq_mask);
  assign run     = (st == S_RUN);
  assign waiting = (st == S_WAIT) || (st == S_HWAIT);

  always_comb begin
    wlog = BASE_LOG + STEP_LOG * int'(ost_sel);
    if (wlog > CAP_LOG) wlog = CAP_LOG;
    last = CW'((64'd1 << wlog) - 64'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN: begin
          cnt <= '0;
          if (stop_strobe && !sub_clk_sel) st <= wake ? S_HWAIT : S_STOP;
        end
        S_STOP: begin
          cnt <= '0;
          if (wake) st <= S_WAIT;
        end
        default: begin
          if (cnt == last) begin
            st  <= S_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q   <= '0;
      ahi_hold <= '0;
    end else if (run) begin
      ahi_hold <= cpu_ad_hi;
      if (port_we) port_q <= port_d;
    end
  end

  assign main_osc_en  = (st != S_STOP);
  assign x2_pullup_en = (st == S_STOP);
  assign sub_osc_en   = sub_clk_cfg;
  assign cpu_clk_en   = run && !waiting;
  assign wdt_en       = run;
  assign adc_en       = run;
  assign ad_lo        = cpu_ad_lo;
  assign ad_lo_oe     = run && cpu_ad_oe;
  assign ad_hi        = run ? cpu_ad_hi : ahi_hold;
  assign astb         = run && cpu_astb;
  assign wr_n         = !run || cpu_wr_n;
  assign rd_n         = !run || cpu_rd_n;
  assign state_o      = st;
endmodule

module stop_ctrl_chk #(
  parameter int N_IRQ = 8,
  parameter int P_W   = 8,
  parameter int AH_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_strobe,
  input logic             sub_clk_sel,
  input logic             sub_clk_cfg,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_mask,
  input logic             main_osc_en,
  input logic             sub_osc_en,
  input logic             x2_pullup_en,
  input logic             cpu_clk_en,
  input logic             wdt_en,
  input logic             adc_en,
  input logic [P_W-1:0]   port_q,
  input logic             ad_lo_oe,
  input logic [AH_W-1:0]  ad_hi,
  input logic             astb,
  input logic             wr_n,
  input logic             rd_n,
  input logic [1:0]       state_o
);
  logic wk;
  assign wk = |(irq_req & ~irq_mask);

  AST_SUB_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && stop_strobe && sub_clk_sel) |=> state_o == 2'd0); // R1
  AST_ENTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && stop_strobe && !sub_clk_sel && !wk) |=> (state_o == 2'd1 && !main_osc_en && x2_pullup_en)); // R2
  AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && wk) |=> state_o == 2'd2); // R3
  AST_STAY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && !wk) |=> state_o == 2'd1); // R3
  AST_HALT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && stop_strobe && !sub_clk_sel && wk) |=> (state_o == 2'd3 && main_osc_en)); // R4
  AST_AHI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0) |=> (state_o == 2'd0 || $stable(ad_hi))); // R6
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0) |-> (!ad_lo_oe && !astb && wr_n && rd_n)); // R7
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0) |=> (state_o == 2'd0 || $stable(port_q))); // R8
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0) |-> (!cpu_clk_en && !wdt_en && !adc_en)); // R9
  AST_SUB_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    sub_osc_en == sub_clk_cfg); // R2
endmodule

bind stop_ctrl stop_ctrl_chk #(.N_IRQ(N_IRQ), .P_W(P_W), .AH_W(AH_W)) u_chk (.*);

// File: tb/test_stop_ctrl.sv
`timescale 1ns/1ps
module test_stop_ctrl;
  localparam int NI = 4, PW = 8, ALW = 8, AHW = 8, BL = 2, SL = 1, CL = 6;

  logic clk = 0, rst_n = 0;
  logic stop_strobe = 0, sub_clk_sel = 0, sub_clk_cfg = 1;
  logic [NI-1:0] irq_req = '0, irq_mask = '0;
  logic [2:0] ost_sel = '0;
  logic [PW-1:0] port_d = '0;
  logic port_we = 0;
  logic [ALW-1:0] cpu_ad_lo = 8'h3c;
  logic cpu_ad_oe = 1;
  logic [AHW-1:0] cpu_ad_hi = 8'h00;
  logic cpu_astb = 1, cpu_wr_n = 0, cpu_rd_n = 0;
  logic main_osc_en, sub_osc_en, x2_pullup_en, cpu_clk_en, wdt_en, adc_en;
  logic [PW-1:0] port_q;
  logic [ALW-1:0] ad_lo;
  logic ad_lo_oe, astb, wr_n, rd_n;
  logic [AHW-1:0] ad_hi;
  logic [1:0] state_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stop_ctrl #(.N_IRQ(NI), .P_W(PW), .AL_W(ALW), .AH_W(AHW),
              .BASE_LOG(BL), .STEP_LOG(SL), .CAP_LOG(CL)) i_stop_ctrl (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wait_len(int sel);
    int l = BL + SL * sel;
    if (l > CL) l = CL;
    return 1 << l;
  endfunction

  task automatic measure(string req, int exp);
    int n = 0;
    while (state_o != 2'd0 && n < 1000) begin
      @(negedge clk);
      n++;
      if (state_o != 2'd0) chk("R9", {29'd0, cpu_clk_en, wdt_en, adc_en}, 0);
    end
    chk(req, n, exp);
    chk("R9", {29'd0, cpu_clk_en, wdt_en, adc_en}, 7);
  endtask

  initial begin
    #500000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", state_o, 0);
    chk("R10", main_osc_en, 1);
    chk("R10", port_q, 0);
    chk("R10", ad_lo_oe, 1);
    chk("R10", astb, 1);
    rst_n = 1;
    @(negedge clk);

    // R1 strobe ignored on subsystem clock
    sub_clk_sel = 1; stop_strobe = 1;
    @(negedge clk); stop_strobe = 0;
    chk("R1", state_o, 0);
    chk("R1", main_osc_en, 1);
    chk("R1", cpu_clk_en, 1);
    sub_clk_sel = 0;

    for (int sel = 0; sel < 8; sel++) begin
      for (int cfg = 0; cfg < 2; cfg++) begin
        ost_sel = 3'(sel); sub_clk_cfg = cfg[0];
        cpu_ad_hi = 8'(8'h40 + sel * 2 + cfg);
        port_d = 8'(sel * 16 + cfg + 1); port_we = 1;
        @(negedge clk); port_we = 0;
        chk("R8", port_q, sel * 16 + cfg + 1);
        // enter STOP
        stop_strobe = 1;
        @(negedge clk); stop_strobe = 0;
        chk("R1", state_o, 1);
        chk("R2", {30'd0, main_osc_en, x2_pullup_en}, 1);
        chk("R2", sub_osc_en, cfg);
        // masked requests and disturbances must not matter
        cpu_ad_hi = 8'hff; irq_req = 4'b1010; irq_mask = 4'b1010;
        port_d = 8'hee; port_we = 1;
        repeat (3) @(negedge clk);
        port_we = 0;
        chk("R3", state_o, 1);
        chk("R8", port_q, sel * 16 + cfg + 1);
        chk("R6", ad_hi, 8'h40 + sel * 2 + cfg);
        chk("R6", ad_lo_oe, 0);
        chk("R7", {29'd0, astb, wr_n, rd_n}, 3);
        // unmasked wake on one bit
        irq_mask = 4'b1000;
        @(negedge clk);
        irq_req = '0; irq_mask = '0;
        chk("R3", state_o, 2);
        chk("R2", {30'd0, main_osc_en, x2_pullup_en}, 2);
        measure("R5", wait_len(sel));
        cpu_ad_hi = 8'h11;

        // pending interrupt at strobe: HALT_WAIT
        irq_req = NI'(1 << (sel % NI)); stop_strobe = 1;
        @(negedge clk); stop_strobe = 0; irq_req = '0;
        chk("R4", state_o, 3);
        chk("R4", main_osc_en, 1);
        chk("R7", {29'd0, astb, wr_n, rd_n}, 3);
        chk("R6", ad_hi, 8'h11);
        measure("R5", wait_len(sel));
      end
    end

    // R8 port write in RUN is live
    port_d = 8'h5a; port_we = 1;
    @(negedge clk); port_we = 0;
    chk("R8", port_q, 8'h5a);
    chk("R7", {29'd0, astb, wr_n, rd_n}, 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule